// File: doc/BRIEF.md
# Carry Flag and ALU Carry Control

This block is the carry path that sits beside an 8-bit ALU. It holds the architectural carry flag and decides what gets written into it. The candidate values are the ALU carry out of bit 7, the decimal-adjust signal that reports a high BCD digit of ten or more, accumulator bit 0 for right rotates, and the current flag itself. A single result-invert control then flips the chosen value. With the flag as the source, that inversion gives complement-carry. With the ALU carry as the source, it turns carry into borrow for subtract and compare. With no source selected, it gives set-carry when asserted and clear-carry when low.

The same block produces the carry-in fed to the ALU and the input for the top bit during right shifts. The carry-in is a constant, or the current flag, or a private latched carry. In each case a carry-in invert control can flip it. The private latch holds the carry of the low byte of a 16-bit add-constant operation, so the high byte can add it in while the architectural flag stays untouched.

One control line does two jobs, since the operations that use them never overlap. It selects the latched carry as the ALU carry-in, and it selects accumulator bit 0 as the shift-right input, which makes the rotate circular. Instruction decoding happens elsewhere. This block only acts on the control lines it is given.

Top module: `carry_path`

## Requirements
- R1: After reset the carry flag is 0 and the private latch is 0. With the shared rotate/latch line high and no carry-in inversion, alu_cin reads 0 and shr_in shows acc_b0.
- R2: The carry flag loads only on a clock edge where flag_we is high. Otherwise it keeps its value, whatever the source and invert controls are.
- R3: res_sel is one-hot or all zero. bit 0 selects alu_c7, bit 1 selects hi_ge10, bit 3 selects acc_b0. On a flag_we edge the flag takes the selected value XOR res_inv, which covers carry, borrow, decimal adjust and rotate-right.
- R4: With res_sel bit 2 (the current flag) and res_inv high, a flag_we edge inverts the flag. With res_inv low the flag is reloaded unchanged.
- R5: With res_sel all zero, a flag_we edge loads res_inv: 1 for set-carry, 0 for clear-carry and for AND.
- R6: With cin_from_flag and rot_or_latch both low, alu_cin equals cin_inv, combinationally.
- R7: With cin_from_flag high, alu_cin equals carry_flag XOR cin_inv, combinationally.
- R8: The private latch captures alu_c7 on an edge where latch_we is high and holds otherwise. The carry flag is not affected. With rot_or_latch high and cin_from_flag low, alu_cin equals the latch XOR cin_inv.
- R9: shr_in equals carry_flag when rot_or_latch is low and acc_b0 when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_c7 | input | 1 | ALU carry out of bit 7 |
| hi_ge10 | input | 1 | High BCD digit is ten or more |
| acc_b0 | input | 1 | Accumulator/operand bit 0 |
| res_sel | input | 4 | One-hot source select for the next flag value |
| res_inv | input | 1 | Invert the selected flag value |
| flag_we | input | 1 | Store enable for the carry flag |
| cin_from_flag | input | 1 | Carry-in from the carry flag |
| rot_or_latch | input | 1 | Shared line: carry-in from latch, and circular shift-right input |
| cin_inv | input | 1 | Invert the carry-in |
| latch_we | input | 1 | Capture alu_c7 into the private latch |
| carry_flag | output | 1 | Architectural carry flag |
| alu_cin | output | 1 | Carry-in to the ALU |
| shr_in | output | 1 | Top-bit input for right shifts |

## Verification
The private latch is the hardest state to observe. It has no output of its own, and it can only be seen through alu_cin while the shared line is high and the flag source is off. The sweep writes the latch on some cycles with flag_we low, then reads it through alu_cin on later cycles. This checks both that the latch took the right value and that the flag did not move. Complement-carry depends on the flag's own history, so the sweep runs every source and invert combination from both flag states, with the bench carrying its own model of the flag and the latch from cycle to cycle.

// File: rtl/carry_pkg.sv
package carry_pkg;
  localparam int unsigned SRC_W = 4;

  typedef enum int unsigned {
    SRC_ALU  = 0,
    SRC_DEC  = 1,
    SRC_FLAG = 2,
    SRC_ACC0 = 3
  } src_idx_e;

  // Optional inversion used by both the result path and the carry-in path.
  function automatic logic flip_if(input logic v, input logic inv);
    return v ^ inv;
  endfunction

  // Carry-in base: flag has priority over the latch; neither gives constant 0.
  function automatic logic cin_base(input logic use_flag, input logic use_latch,
                                    input logic flag, input logic latch_v);
    if (use_flag)       return flag;
    else if (use_latch) return latch_v;
    else                return 1'b0;
  endfunction
endpackage

// File: rtl/carry_onehot_mux.sv
module carry_onehot_mux #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] sel,
  input  logic [N-1:0] src,
  output logic         y
);
  logic [N-1:0] term;

  for (genvar i = 0; i < N; i++) begin : g_term
    assign term[i] = sel[i] & src[i];
  end

  assign y = |term;
endmodule

// File: rtl/carry_in_mux.sv
module carry_in_mux
  import carry_pkg::*;
(
  input  logic flag,
  input  logic latch_v,
  input  logic use_flag,
  input  logic use_latch,
  input  logic inv,
  output logic cin
);
  assign cin = flip_if(cin_base(use_flag, use_latch, flag, latch_v), inv);
endmodule

// File: rtl/shift_in_mux.sv
module shift_in_mux (
  input  logic flag,
  input  logic acc0,
  input  logic rot,
  output logic y
);
  assign y = rot ? acc0 : flag;
endmodule

// File: rtl/carry_path.sv
module carry_path
  import carry_pkg::*;
#(
  parameter int unsigned NSRC = SRC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alu_c7,
  input  logic            hi_ge10,
  input  logic            acc_b0,
  input  logic [NSRC-1:0] res_sel,
  input  logic            res_inv,
  input  logic            flag_we,
  input  logic            cin_from_flag,
  input  logic            rot_or_latch,
  input  logic            cin_inv,
  input  logic            latch_we,
  output logic            carry_flag,
  output logic            alu_cin,
  output logic            shr_in
);
  localparam int unsigned LAST = NSRC - 1;

  logic            flag_q;
  logic            latch_q;
  logic [NSRC-1:0] src_vec;
  logic            picked;
  logic            next_flag;

  always_comb begin
    src_vec           = '0;
    src_vec[SRC_ALU]  = alu_c7;
    src_vec[SRC_DEC]  = hi_ge10;
    src_vec[SRC_FLAG] = flag_q;
    src_vec[LAST]     = acc_b0;
  end

  carry_onehot_mux #(.N(NSRC)) u_res (
    .sel (res_sel),
    .src (src_vec),
    .y   (picked)
  );

  assign next_flag = flip_if(picked, res_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_we) flag_q <= next_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (latch_we) latch_q <= alu_c7;
  end

  carry_in_mux u_cin (
    .flag      (flag_q),
    .latch_v   (latch_q),
    .use_flag  (cin_from_flag),
    .use_latch (rot_or_latch),
    .inv       (cin_inv),
    .cin       (alu_cin)
  );

  shift_in_mux u_shr (
    .flag (flag_q),
    .acc0 (acc_b0),
    .rot  (rot_or_latch),
    .y    (shr_in)
  );

  assign carry_flag = flag_q;

  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(carry_flag));

  // R3
  res_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_sel));

  // R3
  alu_carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && res_sel == NSRC'(1)) |=> carry_flag == $past(alu_c7 ^ res_inv));

  // R4
  cmc_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && res_sel == NSRC'(4) && res_inv) |=> carry_flag != $past(carry_flag));

  // R5
  set_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && res_sel == '0) |=> carry_flag == $past(res_inv));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_we |=> $stable(latch_q));

  // R9
  shr_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_or_latch |-> shr_in == acc_b0);
endmodule

// File: tb/sim_carry_path.sv
`timescale 1ns/1ps
module sim_carry_path;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alu_c7 = 0, hi_ge10 = 0, acc_b0 = 0;
  logic [3:0] res_sel = '0;
  logic res_inv = 0, flag_we = 0, cin_from_flag = 0, rot_or_latch = 0;
  logic cin_inv = 0, latch_we = 0;
  logic carry_flag, alu_cin, shr_in;

  int n_tests = 0;
  int n_fail  = 0;
  logic m_flag = 0, m_latch = 0;
  bit done = 0;

  always #4 clk = ~clk;

  carry_path u0 (
    .clk(clk), .rst_n(rst_n), .alu_c7(alu_c7), .hi_ge10(hi_ge10), .acc_b0(acc_b0),
    .res_sel(res_sel), .res_inv(res_inv), .flag_we(flag_we),
    .cin_from_flag(cin_from_flag), .rot_or_latch(rot_or_latch), .cin_inv(cin_inv),
    .latch_we(latch_we), .carry_flag(carry_flag), .alu_cin(alu_cin), .shr_in(shr_in)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Bench restatement of the next flag value from the requirements.
  function automatic logic exp_next(input logic [3:0] s, input logic f);
    logic v;
    case (s)
      4'b0001: v = alu_c7;
      4'b0010: v = hi_ge10;
      4'b0100: v = f;
      4'b1000: v = acc_b0;
      default: v = 1'b0;
    endcase
    return (v ^ res_inv);
  endfunction

  task automatic step();
    logic expc;
    #1;
    if (cin_from_flag)     expc = m_flag ^ cin_inv;
    else if (rot_or_latch) expc = m_latch ^ cin_inv;
    else                   expc = cin_inv;
    chk(alu_cin, expc, rot_or_latch && !cin_from_flag ? "R8 cin from latch" :
                       cin_from_flag ? "R7 cin from flag" : "R6 constant cin");
    chk(shr_in, rot_or_latch ? acc_b0 : m_flag, "R9 shift-right input");
    @(posedge clk);
    if (flag_we) m_flag = exp_next(res_sel, m_flag);
    if (latch_we) m_latch = alu_c7;
    #1;
    chk(carry_flag, m_flag, !flag_we ? "R2 flag hold" :
                            res_sel == 4'b0100 ? "R4 complement" :
                            res_sel == 4'b0000 ? "R5 set/clear" : "R3 source load");
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    rot_or_latch = 1; acc_b0 = 1;
    #1;
    chk(carry_flag, 1'b0, "R1 flag after reset");
    chk(alu_cin, 1'b0, "R1 latch after reset");
    chk(shr_in, 1'b1, "R1 shift-right input after reset");
    rst_n = 1;
    rot_or_latch = 0; acc_b0 = 0;
    @(negedge clk);

    for (int s = 0; s < 5; s++) begin
      for (int v = 0; v < 256; v++) begin
        res_sel       = (s == 4) ? 4'b0000 : 4'(1 << s);
        res_inv       = v[0];
        alu_c7        = v[1];
        hi_ge10       = v[2];
        acc_b0        = v[3];
        flag_we       = v[4];
        cin_from_flag = v[5];
        rot_or_latch  = v[6] & ~v[5];
        cin_inv       = v[7];
        latch_we      = v[3] ^ v[2];
        step();
      end
    end

    // R8: latch a carry with the flag frozen, then read it back through carry-in
    res_sel = 4'b0000; res_inv = 1; flag_we = 1; latch_we = 0;
    cin_from_flag = 0; rot_or_latch = 0; cin_inv = 0;
    step();
    flag_we = 0; latch_we = 1; alu_c7 = 0;
    step();
    latch_we = 0; alu_c7 = 1; rot_or_latch = 1;
    step();
    chk(alu_cin, 1'b0, "R8 latch held low");
    chk(carry_flag, 1'b1, "R8 flag untouched by latch");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule